// File: doc/BRIEF.md
# Instruction-Decoded 16-bit ALU

This block is the combinational execute unit of a small 16-bit load/store processor. It takes the raw instruction word and the two operands read from the register file, and returns one 16-bit result in the same cycle. It has no clock and no state.

The instruction's top four bits pick a unit: arithmetic, bitwise logic, compare, or shift/modulo. Lower fields of the instruction pick the operation within that unit, or supply a small immediate that replaces the second operand. Compares return minus one, zero or plus one. They work by subtracting operands widened to 17 bits. Shifts by an immediate amount go through a log-depth barrel shifter.

Top module: `alu16_decode`

## Requirements
- R1: Any opcode `insn[15:12]` other than 0001, 0010, 0101 or 1010 yields a result of 16'h0000, whatever the other bits and operands are.
- R2: Opcode 0001 with `insn[5]`=0 gives ADD (`insn[4:3]`=00) as `src_a+src_b` and SUB (10) as `src_a-src_b`, both modulo 2^16. With `insn[5]`=1 it gives `src_a` plus `insn[4:0]` sign-extended.
- R3: Opcode 0001 with `insn[5:3]`=001 gives the low 16 bits of `src_a*src_b`.
- R4: Opcode 0001 with `insn[5:3]`=011 gives the unsigned quotient `src_a/src_b`, and 0 when `src_b` is 0.
- R5: Opcode 1010 with `insn[5:4]`=11 gives the unsigned remainder `src_a%src_b`, and 0 when `src_b` is 0.
- R6: Opcode 0101 with `insn[5]`=0 selects on `insn[4:3]`: AND=00, NOT of `src_a`=01, OR=10, XOR=11. With `insn[5]`=1 it gives `src_a` AND `insn[4:0]` sign-extended.
- R7: Opcode 0010 does a signed compare of `src_a` against `src_b` when `insn[8:7]`=00, or against `insn[6:0]` sign-extended when it is 10. The result is 16'hFFFF when less, 0 when equal, and 16'h0001 when greater.
- R8: Opcode 0010 does an unsigned compare of `src_a` against `src_b` when `insn[8:7]`=01, or against `insn[6:0]` zero-extended when it is 11. The result encoding is the same as in R7.
- R9: Opcode 1010 with `insn[5:4]`=00 shifts `src_a` left, and with 10 shifts it right, by `insn[3:0]` places (0 to 15). Vacated bits are filled with zeros.
- R10: Opcode 1010 with `insn[5:4]`=01 shifts `src_a` right by `insn[3:0]` places and fills the vacated bits with copies of bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 16 | Instruction word: opcode, sub-operation and immediate fields |
| src_a | input | 16 | First register operand |
| src_b | input | 16 | Second register operand |
| result | output | 16 | Operation result |

## Verification
The bench builds the block at its default 16-bit width. At that width the shift field covers every amount from 0 to 15, and the barrel shifter runs all four of its stages. Every 5-bit and 7-bit immediate can also be swept in full. The operand set includes 16'h8000 and 16'h7FFF, so signed and unsigned compares disagree on the same pair. Zero divisors, wrap-around on add and subtract, and products that overflow are also reached.

// File: rtl/alu16_pkg.sv
// Shared opcode values and unit-select type for the instruction-decoded ALU.
// Assumes a 16-bit instruction with the opcode in its top four bits.
package alu16_pkg;

    localparam int INSN_W = 16;
    localparam int OPC_W  = 4;

    localparam logic [OPC_W-1:0] OPC_ARITH = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_CMP   = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_SHIFT = 4'b1010;

    typedef enum logic [2:0] {
        UNIT_NONE,
        UNIT_ARITH,
        UNIT_LOGIC,
        UNIT_CMP,
        UNIT_SHIFT
    } unit_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_ARITH = 2'b01,
        SH_RIGHT = 2'b10,
        SH_MOD   = 2'b11
    } shift_op_e;

endpackage

// File: rtl/alu16_arith.sv
// Arithmetic unit: add, multiply (low half), subtract and unsigned divide.
// Assumes the second operand has already been replaced by an immediate where
// required. A zero divisor gives a zero quotient.
module alu16_arith #(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);

    // Select one arithmetic result by the two-bit operation code.
    always_comb begin
        case (op)
            2'b00:   res = opa + opb;
            2'b01:   res = opa * opb;
            2'b10:   res = opa - opb;
            default: res = (opb == '0) ? '0 : opa / opb;
        endcase
    end

endmodule

// File: rtl/alu16_logic.sv
// Bitwise logic unit: AND, NOT (of the first operand), OR, XOR.
// Assumes the second operand has been replaced by an immediate where needed.
module alu16_logic #(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);

    // Select one bitwise result by the two-bit operation code.
    always_comb begin
        case (op)
            2'b00:   res = opa & opb;
            2'b01:   res = ~opa;
            2'b10:   res = opa | opb;
            default: res = opa ^ opb;
        endcase
    end

endmodule

// File: rtl/alu16_cmp.sv
// Three-way compare. Both operands are widened by one bit, with sign or zero
// fill, and subtracted. The sign and zero state of the widened difference
// give all-ones, zero or one.
module alu16_cmp #(
    parameter int DATA_W = 16
) (
    input  logic              signed_mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] diff;

    // Widen the operands by one bit and take their difference.
    always_comb begin
        ext_a = {signed_mode & opa[DATA_W-1], opa};
        ext_b = {signed_mode & opb[DATA_W-1], opb};
        diff  = ext_a - ext_b;
    end

    // Map the difference onto the -1 / 0 / +1 result encoding.
    always_comb begin
        if (diff == '0)
            res = '0;
        else if (diff[EXT_W-1])
            res = '1;
        else
            res = DATA_W'(1);
    end

endmodule

// File: rtl/alu16_shift.sv
// Barrel shifter built from log2(DATA_W) stages. Each stage conditionally
// shifts by a power of two. Supports left, logical right and arithmetic
// right. Assumes DATA_W is a power of two.
module alu16_shift #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic              left,
    input  logic              arith,
    input  logic [AMT_W-1:0]  amt,
    input  logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] res
);

    logic [DATA_W-1:0] stage [AMT_W+1];
    logic              fill;

    // Fill bit for right shifts: a copy of the sign bit in arithmetic mode.
    always_comb fill = arith & opa[DATA_W-1];

    assign stage[0] = opa;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        // Shift by DIST places when this bit of the amount is set.
        always_comb begin
            if (!amt[s])
                stage[s+1] = stage[s];
            else if (left)
                stage[s+1] = {stage[s][DATA_W-DIST-1:0], {DIST{1'b0}}};
            else
                stage[s+1] = {{DIST{fill}}, stage[s][DATA_W-1:DIST]};
        end
    end

    assign res = stage[AMT_W];

endmodule

// File: rtl/alu16_decode.sv
// Top of the instruction-decoded ALU. Decodes the opcode and sub-operation
// fields, forms immediates, feeds the unit datapaths and selects one result.
// Purely combinational. Opcodes without a unit give zero.
module alu16_decode
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result
);

    localparam int AMT_W  = $clog2(DATA_W);
    localparam int IMM5_W = 5;
    localparam int IMM7_W = 7;

    unit_e             unit;
    logic [DATA_W-1:0] imm5_sx;
    logic [DATA_W-1:0] imm7_ext;
    logic [DATA_W-1:0] arith_b, logic_b, cmp_b;
    logic [1:0]        arith_op, logic_op;
    logic              cmp_signed;
    shift_op_e         sh_op;
    logic [DATA_W-1:0] arith_res, logic_res, cmp_res, shift_res, mod_res;
    logic              unused_insn;

    assign unused_insn = ^insn[11:9];

    // Map the opcode onto a functional unit.
    always_comb begin
        case (insn[15:12])
            OPC_ARITH: unit = UNIT_ARITH;
            OPC_LOGIC: unit = UNIT_LOGIC;
            OPC_CMP:   unit = UNIT_CMP;
            OPC_SHIFT: unit = UNIT_SHIFT;
            default:   unit = UNIT_NONE;
        endcase
    end

    // Form the immediates: imm5 is sign-extended, imm7 is sign- or zero-extended.
    always_comb begin
        imm5_sx    = {{(DATA_W-IMM5_W){insn[IMM5_W-1]}}, insn[IMM5_W-1:0]};
        cmp_signed = ~insn[7];
        imm7_ext   = {{(DATA_W-IMM7_W){cmp_signed & insn[IMM7_W-1]}}, insn[IMM7_W-1:0]};
    end

    // Immediate forms force ADD / AND and replace the second operand.
    always_comb begin
        arith_op = insn[5] ? 2'b00 : insn[4:3];
        logic_op = insn[5] ? 2'b00 : insn[4:3];
        arith_b  = insn[5] ? imm5_sx : src_b;
        logic_b  = insn[5] ? imm5_sx : src_b;
        cmp_b    = insn[8] ? imm7_ext : src_b;
        sh_op    = shift_op_e'(insn[5:4]);
    end

    alu16_arith #(.DATA_W(DATA_W)) u_arith (
        .op (arith_op),
        .opa(src_a),
        .opb(arith_b),
        .res(arith_res)
    );

    alu16_logic #(.DATA_W(DATA_W)) u_logic (
        .op (logic_op),
        .opa(src_a),
        .opb(logic_b),
        .res(logic_res)
    );

    alu16_cmp #(.DATA_W(DATA_W)) u_cmp (
        .signed_mode(cmp_signed),
        .opa        (src_a),
        .opb        (cmp_b),
        .res        (cmp_res)
    );

    alu16_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .left (sh_op == SH_LEFT),
        .arith(sh_op == SH_ARITH),
        .amt  (insn[AMT_W-1:0]),
        .opa  (src_a),
        .res  (shift_res)
    );

    // Unsigned remainder shares the shift opcode; a zero divisor gives zero.
    always_comb mod_res = (src_b == '0) ? '0 : src_a % src_b;

    // Final result select by functional unit.
    always_comb begin
        case (unit)
            UNIT_ARITH: result = arith_res;
            UNIT_LOGIC: result = logic_res;
            UNIT_CMP:   result = cmp_res;
            UNIT_SHIFT: result = (sh_op == SH_MOD) ? mod_res : shift_res;
            default:    result = '0;
        endcase
    end

endmodule

// File: rtl/alu16_decode_chk.sv
// Port-level checker for the instruction-decoded ALU. It uses immediate
// assertions because the block has no clock. Each check is skipped while
// any port is unknown.
module alu16_decode_chk #(
    parameter int DATA_W = 16
) (
    input logic [15:0]       insn,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] result
);

    logic known;
    logic is_cmp;

    always_comb known  = !$isunknown({insn, src_a, src_b, result});
    always_comb is_cmp = (insn[15:12] == 4'b0010);

    // Port relations that must hold for every input combination.
    always_comb begin
        if (known) begin
            a_r1_unlisted_zero: assert (!(insn[15:12] != 4'b0001 && insn[15:12] != 4'b0010 &&
                                          insn[15:12] != 4'b0101 && insn[15:12] != 4'b1010)
                                        || result == '0);
            a_r7_cmp_encoding: assert (!is_cmp || result == '0 || result == '1 ||
                                       result == DATA_W'(1));
            a_r7_cmp_equal: assert (!(is_cmp && !insn[8] && src_a == src_b) || result == '0);
            a_r4_div_by_zero: assert (!(insn[15:12] == 4'b0001 && insn[5:3] == 3'b011 &&
                                        src_b == '0) || result == '0);
            a_r5_mod_by_zero: assert (!(insn[15:12] == 4'b1010 && insn[5:4] == 2'b11 &&
                                        src_b == '0) || result == '0);
            a_r9_shift_by_zero: assert (!(insn[15:12] == 4'b1010 && insn[5:4] != 2'b11 &&
                                          insn[3:0] == 4'd0) || result == src_a);
        end
    end

endmodule

bind alu16_decode alu16_decode_chk #(.DATA_W(DATA_W)) u_chk (
    .insn  (insn),
    .src_a (src_a),
    .src_b (src_b),
    .result(result)
);

// File: tb/alu16_decode_tb.sv
`timescale 1ns / 1ps
// Self-checking bench: a table of hand-worked vectors, then sweeps against
// an independent reference model.
module alu16_decode_tb;

    localparam int    NVEC   = 22;
    localparam int    NOPS   = 6;
    localparam time   PERIOD = 20ns;

    logic        clk = 1'b0;
    logic [15:0] insn = '0, src_a = '0, src_b = '0;
    logic [15:0] result;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    alu16_decode u_dut (.insn(insn), .src_a(src_a), .src_b(src_b), .result(result));

    // {insn, src_a, src_b, expected, requirement number}
    localparam logic [71:0] VEC [NVEC] = '{
        {16'h1000, 16'h1234, 16'h1111, 16'h2345, 8'd2},  // R2 add
        {16'h1000, 16'hFFFF, 16'h0002, 16'h0001, 8'd2},  // R2 add wraps
        {16'h103F, 16'h0005, 16'h0000, 16'h0004, 8'd2},  // R2 add imm -1
        {16'h1010, 16'h0003, 16'h0005, 16'hFFFE, 8'd2},  // R2 sub
        {16'h1008, 16'h0100, 16'h0101, 16'h0100, 8'd3},  // R3 mul low half
        {16'h1018, 16'h0064, 16'h0007, 16'h000E, 8'd4},  // R4 div
        {16'h1018, 16'h0064, 16'h0000, 16'h0000, 8'd4},  // R4 div by zero
        {16'hA030, 16'h0064, 16'h0007, 16'h0002, 8'd5},  // R5 mod
        {16'hA030, 16'h1234, 16'h0000, 16'h0000, 8'd5},  // R5 mod by zero
        {16'h5000, 16'hF0F0, 16'hFF00, 16'hF000, 8'd6},  // R6 and
        {16'h5008, 16'hF0F0, 16'h0000, 16'h0F0F, 8'd6},  // R6 not
        {16'h5010, 16'hF0F0, 16'h0F00, 16'hFFF0, 8'd6},  // R6 or
        {16'h5018, 16'hFFFF, 16'h0F0F, 16'hF0F0, 8'd6},  // R6 xor
        {16'h5030, 16'h1234, 16'h0000, 16'h1230, 8'd6},  // R6 and imm -16
        {16'h2000, 16'h8000, 16'h7FFF, 16'hFFFF, 8'd7},  // R7 signed less
        {16'h2080, 16'h8000, 16'h7FFF, 16'h0001, 8'd8},  // R8 unsigned greater
        {16'h217F, 16'hFFFF, 16'h0000, 16'h0000, 8'd7},  // R7 imm -1 equal
        {16'h21FF, 16'hFFFF, 16'h0000, 16'h0001, 8'd8},  // R8 imm 127 zero-ext
        {16'hA00F, 16'h0003, 16'h0000, 16'h8000, 8'd9},  // R9 left by 15
        {16'hA02F, 16'h8000, 16'h0000, 16'h0001, 8'd9},  // R9 right by 15
        {16'hA014, 16'h8000, 16'h0000, 16'hF800, 8'd10}, // R10 arith right 4
        {16'hF000, 16'h1234, 16'h0001, 16'h0000, 8'd1}   // R1 unlisted opcode
    };

    localparam logic [15:0] OPS [NOPS] = '{16'h0000, 16'h0001, 16'h7FFF,
                                           16'h8000, 16'hFFFF, 16'h1234};

    // Independent reference model written from the requirements.
    function automatic logic [15:0] ref_alu(input logic [15:0] i, input logic [15:0] a,
                                            input logic [15:0] b);
        logic [15:0] imm5;
        int          va, vb;
        imm5 = {{11{i[4]}}, i[4:0]};
        case (i[15:12])
            4'h1: begin
                if (i[5]) return a + imm5;
                case (i[4:3])
                    2'd0: return a + b;
                    2'd1: return 16'(a * b);
                    2'd2: return a - b;
                    default: return (b == 0) ? 16'h0 : a / b;
                endcase
            end
            4'h5: begin
                if (i[5]) return a & imm5;
                case (i[4:3])
                    2'd0: return a & b;
                    2'd1: return ~a;
                    2'd2: return a | b;
                    default: return a ^ b;
                endcase
            end
            4'h2: begin
                if (!i[7]) begin
                    va = int'($signed(a));
                    vb = i[8] ? int'($signed(i[6:0])) : int'($signed(b));
                end else begin
                    va = int'(a);
                    vb = i[8] ? int'(i[6:0]) : int'(b);
                end
                if (va < vb) return 16'hFFFF;
                if (va > vb) return 16'h0001;
                return 16'h0000;
            end
            4'hA: begin
                case (i[5:4])
                    2'd0: return a << i[3:0];
                    2'd1: return 16'($signed(a) >>> i[3:0]);
                    2'd2: return a >> i[3:0];
                    default: return (b == 0) ? 16'h0 : a % b;
                endcase
            end
            default: return 16'h0000;
        endcase
    endfunction

    // Requirement tag for an instruction, used in check messages.
    function automatic string tag_of(input logic [15:0] i);
        case (i[15:12])
            4'h1: return i[5] ? "R2" : (i[4:3] == 2'd1) ? "R3" :
                         (i[4:3] == 2'd3) ? "R4" : "R2";
            4'h5: return "R6";
            4'h2: return i[7] ? "R8" : "R7";
            4'hA: return (i[5:4] == 2'd3) ? "R5" : (i[5:4] == 2'd1) ? "R10" : "R9";
            default: return "R1";
        endcase
    endfunction

    // Drive inputs after a rising edge, then compare at the falling edge.
    task automatic apply(input logic [15:0] i, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] exp, input string tag);
        @(posedge clk);
        #1;
        insn = i; src_a = a; src_b = b;
        @(negedge clk);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s insn=%h a=%h b=%h got=%h exp=%h", tag, i, a, b, result, exp);
        end
    endtask

    initial begin
        // Idle check: all-zero inputs decode as an unlisted opcode (R1).
        @(negedge clk);
        n_run++;
        if (result !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1 idle got=%h exp=0000", result);
        end

        // Hand-worked vector table.
        for (int v = 0; v < NVEC; v++)
            apply(VEC[v][71:56], VEC[v][55:40], VEC[v][39:24], VEC[v][23:8],
                  $sformatf("table entry %0d req %0d", v, VEC[v][7:0]));

        // Register forms of every sub-operation over corner operand pairs (R2-style sweep).
        for (int o = 0; o < 11; o++) begin
            logic [15:0] base;
            case (o)
                0: base = 16'h1000; 1: base = 16'h1008; 2: base = 16'h1010;
                3: base = 16'h1018; 4: base = 16'h5000; 5: base = 16'h5008;
                6: base = 16'h5010; 7: base = 16'h5018; 8: base = 16'h2000;
                9: base = 16'h2080; default: base = 16'hA030;
            endcase
            for (int x = 0; x < NOPS; x++)
                for (int y = 0; y < NOPS; y++)
                    apply(base, OPS[x], OPS[y], ref_alu(base, OPS[x], OPS[y]), tag_of(base));
        end

        // Every 5-bit immediate for add and and (R2, R6).
        for (int m = 0; m < 32; m++)
            for (int x = 0; x < NOPS; x++) begin
                apply(16'h1020 | 16'(m), OPS[x], 16'hAAAA,
                      ref_alu(16'h1020 | 16'(m), OPS[x], 16'hAAAA), "R2");
                apply(16'h5020 | 16'(m), OPS[x], 16'hAAAA,
                      ref_alu(16'h5020 | 16'(m), OPS[x], 16'hAAAA), "R6");
            end

        // Every 7-bit immediate for signed and unsigned compare (R7, R8).
        for (int m = 0; m < 128; m++)
            for (int x = 0; x < NOPS; x++) begin
                apply(16'h2100 | 16'(m), OPS[x], 16'h0000,
                      ref_alu(16'h2100 | 16'(m), OPS[x], 16'h0000), "R7");
                apply(16'h2180 | 16'(m), OPS[x], 16'h0000,
                      ref_alu(16'h2180 | 16'(m), OPS[x], 16'h0000), "R8");
            end

        // All shift amounts 0..15 in all three shift modes (R9, R10).
        for (int s = 0; s < 3; s++)
            for (int m = 0; m < 16; m++)
                for (int x = 0; x < NOPS; x++) begin
                    logic [15:0] ins;
                    ins = 16'hA000 | 16'(s << 4) | 16'(m);
                    apply(ins, OPS[x], 16'h0000, ref_alu(ins, OPS[x], 16'h0000), tag_of(ins));
                end

        // Unlisted opcodes with all low bits set give zero (R1).
        for (int p = 0; p < 16; p++)
            if (p != 1 && p != 2 && p != 5 && p != 10)
                apply(16'(p << 12) | 16'h0FFF, 16'hFFFF, 16'hFFFF, 16'h0000, "R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule